// File: doc/BRIEF.md
# Calendar Clock with Snapshot Read Latch

This block keeps wall-clock time and a calendar: seconds, minutes, hours, a day-of-week count, day of month, month and a two-digit year. It also holds an 8-bit trim value for the oscillator adjustment logic outside the block. The counters advance on a one-cycle tick pulse. The tick comes from a slow timebase and is synchronized into the bus clock before it reaches the block. A carry chain handles minute, hour, day, month and year rollover. The number of days in a month follows the month, and February has 29 days in years divisible by four.

A simple register bus writes the fields and reads them back. The bus has a write strobe, an address and write data, and read data that is selected combinationally by the address. Field reads pass through a snapshot stage. While the freeze bit of the control register is 0, the read values track the counters. When the freeze bit goes from 0 to 1, the stage keeps a coherent copy of all seven counters until the bit is cleared. The control register also holds a hold-tick bit, which stops time from advancing while software sets it, and a low-power lock bit, which makes the block ignore writes to all fields. The control register itself stays writable.

The recommended start-up flow is: clear the lock bit, set hold-tick, write every field, then clear hold-tick. The bus clock must run at least four times faster than the slow clock that produces the tick. The lock bit exists for operation when that ratio cannot be met. While the lock bit is 1, field read values are not guaranteed.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the control register (address 8, bit0 hold-tick, bit1 freeze, bit2 low-power lock) reads 0. Seconds, minutes, hours, day-of-week, year and trim read 0, and day and month read 1.
- R2: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day, 5 month, 6 year and 7 trim. A write stores the value, which reads back in the following cycle. Counting continues from the written value.
- R3: A tick advances seconds by one at the next clock edge. While hold-tick is 1, ticks are ignored and no field changes.
- R4: Seconds and minutes at 59 wrap to 0 with a carry. Hours at 23 wrap to 0 and carry into both day-of-week and day. Day-of-week wraps from 6 to 0.
- R5: The day wraps to 1 after the last day of the month and carries into the month. The last day is 30 for months 4, 6, 9 and 11. It is 29 for month 2 when year mod 4 is 0, and 28 for month 2 otherwise. It is 31 for every other month value. The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R6: An out-of-range value is stored as written. At its next increment, any field at or above its maximum wraps to its minimum and carries.
- R7: While the lock bit is 1, writes to addresses 0 to 7 are ignored. Writes to the control register still take effect.
- R8: On the edge where freeze goes from 0 to 1, reads of addresses 0 to 6 capture the counter values from before that edge. While freeze stays 1, those reads stay constant as time advances.
- R9: While freeze is 0, reads of addresses 0 to 6 show the live counters in the same cycle they change.
- R10: A write and an increment of the same field in the same cycle store the written value. The carry computed from the field's previous value still propagates to the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle once-per-second pulse, already synchronized into the bus clock |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | AW (4) | Register address |
| bus_wdata_i | input | DW (8) | Write data |
| bus_rdata_o | output | DW (8) | Read data selected by bus_addr_i |

## Verification
A wrong counter or carry state shows up at the read port in the cycle after the faulty edge, as long as freeze is 0. A wrong wrap therefore appears on the first tick that crosses a boundary. Month-length errors are visible only on the tick that leaves the last day, so the directed cases put the clock one second before the ends of February, April and December. A snapshot that fails to hold shows up as a read value that changes across ticks while freeze is 1. A lock that leaks shows up as a changed field value once the lock is released.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int NF         = 7;
   localparam int ADDR_TRIM  = 7;
   localparam int ADDR_CTRL  = 8;
   localparam int F_HOUR     = 2;
   localparam int F_DOW      = 3;
   localparam int F_DAY      = 4;
   localparam int F_MON      = 5;
   localparam int F_YEAR     = 6;

   // minimum (reset and wrap target) and maximum of each field
   localparam int FIELD_LO  [NF] = '{0, 0, 0, 0, 1, 1, 0};
   localparam int FIELD_MAX [NF] = '{59, 59, 23, 6, 31, 12, 99};
   // field whose carry increments this one; -1 means the gated tick
   localparam int FIELD_SRC [NF] = '{-1, 0, 1, 2, 2, 4, 5};

   typedef struct packed {
      logic lock;
      logic freeze;
      logic hold;
   } rtc_ctrl_t;
endpackage

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr #(
   parameter int W  = 8,
   parameter int LO = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] max_i,
   output logic [W-1:0] val_o,
   output logic         carry_o
);
   logic [W-1:0] val_q;

   assign carry_o = inc_i && (val_q >= max_i);
   assign val_o   = val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      val_q <= W'(LO);
      else if (wr_i)   val_q <= wdata_i;
      else if (inc_i)  val_q <= (val_q >= max_i) ? W'(LO) : val_q + 1'b1;
   end

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && val_q < max_i) |=> val_q == $past(val_q) + 1'b1);
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && val_q >= max_i) |=> val_q == W'(LO));
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> val_q == $past(wdata_i));
   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !wr_i) |=> $stable(val_q));
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] month_i,
   input  logic [1:0]    year_lo_i,
   output logic [DW-1:0] last_o
);
   always_comb begin
      case (month_i)
         DW'(2):                         last_o = (year_lo_i == 2'd0) ? DW'(29) : DW'(28);
         DW'(4), DW'(6), DW'(9), DW'(11): last_o = DW'(30);
         default:                        last_o = DW'(31);
      endcase
   end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
   parameter int NF = 7,
   parameter int DW = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   freeze_i,
   input  logic [NF-1:0][DW-1:0]  live_i,
   output logic [NF-1:0][DW-1:0]  rd_o
);
   logic [NF-1:0][DW-1:0] hold_q;

   // loads every cycle while freeze is low, so the 0->1 edge keeps pre-edge values
   always_ff @(posedge clk) begin
      if (!rst_n)         hold_q <= '0;
      else if (!freeze_i) hold_q <= live_i;
   end

   assign rd_o = freeze_i ? hold_q : live_i;

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_i |=> $stable(hold_q));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sec_tick_i,
   input  logic          bus_we_i,
   input  logic [AW-1:0] bus_addr_i,
   input  logic [DW-1:0] bus_wdata_i,
   output logic [DW-1:0] bus_rdata_o
);
   if (DW < 7) begin : g_dw_chk
      $error("rtc_calendar: DW must hold the value 99");
   end
   if ((1 << AW) <= ADDR_CTRL) begin : g_aw_chk
      $error("rtc_calendar: AW too small for the register map");
   end

   rtc_ctrl_t             ctrl_q;
   logic [DW-1:0]         trim_q;
   logic                  tick_go;
   logic [NF-1:0]         inc, carry, fwr;
   logic [NF-1:0][DW-1:0] live, rd;
   logic [DW-1:0]         day_last;

   assign tick_go = sec_tick_i && !ctrl_q.hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         trim_q <= '0;
      end else if (bus_we_i) begin
         if (bus_addr_i == AW'(ADDR_CTRL))
            ctrl_q <= '{lock: bus_wdata_i[2], freeze: bus_wdata_i[1], hold: bus_wdata_i[0]};
         else if (bus_addr_i == AW'(ADDR_TRIM) && !ctrl_q.lock)
            trim_q <= bus_wdata_i;
      end
   end

   rtc_month_len #(.DW(DW)) u_mlen (
      .month_i   (live[F_MON]),
      .year_lo_i (live[F_YEAR][1:0]),
      .last_o    (day_last)
   );

   for (genvar g = 0; g < NF; g++) begin : g_field
      logic [DW-1:0] max_v;
      if (FIELD_SRC[g] < 0) begin : g_src_tick
         assign inc[g] = tick_go;
      end else begin : g_src_carry
         assign inc[g] = carry[FIELD_SRC[g]];
      end
      if (g == F_DAY) begin : g_max_dyn
         assign max_v = day_last;
      end else begin : g_max_fix
         assign max_v = DW'(FIELD_MAX[g]);
      end
      assign fwr[g] = bus_we_i && !ctrl_q.lock && (bus_addr_i == AW'(g));

      rtc_field_ctr #(.W(DW), .LO(FIELD_LO[g])) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc_i   (inc[g]),
         .wr_i    (fwr[g]),
         .wdata_i (bus_wdata_i),
         .max_i   (max_v),
         .val_o   (live[g]),
         .carry_o (carry[g])
      );
   end

   rtc_snapshot #(.NF(NF), .DW(DW)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze_i (ctrl_q.freeze),
      .live_i   (live),
      .rd_o     (rd)
   );

   always_comb begin
      bus_rdata_o = '0;
      for (int i = 0; i < NF; i++)
         if (bus_addr_i == AW'(i)) bus_rdata_o = rd[i];
      if (bus_addr_i == AW'(ADDR_TRIM)) bus_rdata_o = trim_q;
      if (bus_addr_i == AW'(ADDR_CTRL)) bus_rdata_o = DW'(ctrl_q);
   end

   assert_lock_trim_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.lock && bus_we_i && bus_addr_i == AW'(ADDR_TRIM)) |=> $stable(trim_q));
   assert_hold_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.hold && !fwr[0]) |=> $stable(live[0]));
   assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[F_DOW] && !fwr[F_DOW]) |=> live[F_DOW] == '0);
   assert_year_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[F_YEAR] && !fwr[F_YEAR]) |=> live[F_YEAR] == '0);
   assert_hour_fanout_R4: assert property (@(posedge clk) disable iff (!rst_n)
      carry[F_HOUR] |-> (inc[F_DOW] && inc[F_DAY]));
endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       we = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int checks = 0;
   int failures = 0;

   int f [7];
   int hold [7];
   int trim;
   bit m_hold, m_freeze, m_lock;

   always #2 clk = ~clk;

   rtc_calendar dut_i (
      .clk(clk), .rst_n(rst_n), .sec_tick_i(tick), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
   );

   function automatic int last_day(int m, int y);
      if (m == 2) return ((y % 4) == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   // one-second advance from the rules of R3..R6
   task automatic model_advance();
      int ld;
      ld = last_day(f[5], f[6]);
      if (f[0] < 59) begin f[0]++; return; end
      f[0] = 0;
      if (f[1] < 59) begin f[1]++; return; end
      f[1] = 0;
      if (f[2] < 23) begin f[2]++; return; end
      f[2] = 0;
      f[3] = (f[3] >= 6) ? 0 : f[3] + 1;
      if (f[4] < ld) begin f[4]++; return; end
      f[4] = 1;
      if (f[5] < 12) begin f[5]++; return; end
      f[5] = 1;
      f[6] = (f[6] >= 99) ? 0 : f[6] + 1;
   endtask

   function automatic int model_read(int a);
      if (a < 7) return m_freeze ? hold[a] : f[a];
      if (a == 7) return trim;
      if (a == 8) return {m_lock, m_freeze, m_hold};
      return 0;
   endfunction

   task automatic cyc(bit w, int a, int d, bit t);
      int old_f [7];
      bit old_freeze;
      @(negedge clk);
      we = w; addr = 4'(a); wdata = 8'(d); tick = t;
      @(posedge clk);
      old_f = f;
      old_freeze = m_freeze;
      if (t && !m_hold) model_advance();
      if (w) begin
         if (a == 8) begin
            m_hold = d[0]; m_freeze = d[1]; m_lock = d[2];
         end else if (!m_lock) begin
            if (a < 7) f[a] = d & 8'hFF;
            else if (a == 7) trim = d & 8'hFF;
         end
      end
      if (!old_freeze) hold = old_f;
   endtask

   task automatic rd_chk(int a, string tag);
      int e;
      @(negedge clk);
      we = 1'b0; tick = 1'b0; addr = 4'(a);
      #1;
      e = model_read(a);
      checks++;
      if (rdata !== 8'(e)) begin
         failures++;
         $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, rdata, e);
      end
   endtask

   task automatic chk_all(string tag);
      for (int a = 0; a < 9; a++) rd_chk(a, tag);
   endtask

   task automatic set_time(int s, int mi, int h, int dw, int dy, int mo, int y);
      cyc(1, 0, s, 0); cyc(1, 1, mi, 0); cyc(1, 2, h, 0); cyc(1, 3, dw, 0);
      cyc(1, 4, dy, 0); cyc(1, 5, mo, 0); cyc(1, 6, y, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      f = '{0, 0, 0, 0, 1, 1, 0};
      hold = '{0, 0, 0, 0, 0, 0, 0};
      trim = 0; m_hold = 0; m_freeze = 0; m_lock = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      chk_all("R1 reset");

      // R2: start-up flow, write all fields, read back
      cyc(1, 8, 1, 0);
      set_time(12, 34, 5, 2, 17, 6, 42);
      cyc(1, 7, 8'hA5, 0);
      chk_all("R2 write readback");
      cyc(1, 8, 0, 0);
      cyc(0, 0, 0, 1);
      rd_chk(0, "R2 counting continues");

      // R3: hold-tick suppresses ticks
      cyc(1, 8, 1, 0);
      repeat (5) cyc(0, 0, 0, 1);
      chk_all("R3 hold-tick");
      cyc(1, 8, 0, 0);
      repeat (3) cyc(0, 0, 0, 1);
      rd_chk(0, "R3 tick resumes");

      // R4/R5: full year-end rollover
      cyc(1, 8, 1, 0);
      set_time(59, 59, 23, 6, 31, 12, 99);
      cyc(1, 8, 0, 0);
      cyc(0, 0, 0, 1);
      chk_all("R4 R5 year end rollover");

      // R5: February in leap and non-leap years, 30-day month
      cyc(1, 8, 1, 0);
      set_time(59, 59, 23, 1, 28, 2, 24);
      cyc(1, 8, 0, 0);
      cyc(0, 0, 0, 1);
      rd_chk(4, "R5 leap Feb 29"); rd_chk(5, "R5 leap month");
      cyc(1, 0, 59, 0); cyc(1, 1, 59, 0); cyc(1, 2, 23, 0);
      cyc(0, 0, 0, 1);
      rd_chk(4, "R5 leap Mar 1 day"); rd_chk(5, "R5 leap Mar 1 month");
      cyc(1, 8, 1, 0);
      set_time(59, 59, 23, 3, 28, 2, 23);
      cyc(1, 8, 0, 0);
      cyc(0, 0, 0, 1);
      chk_all("R5 non-leap Feb 28");
      cyc(1, 8, 1, 0);
      set_time(59, 59, 23, 4, 30, 4, 10);
      cyc(1, 8, 0, 0);
      cyc(0, 0, 0, 1);
      chk_all("R5 Apr 30");

      // R6: out-of-range values
      cyc(1, 0, 70, 0);
      rd_chk(0, "R6 stored as written");
      cyc(0, 0, 0, 1);
      rd_chk(0, "R6 wrap"); rd_chk(1, "R6 carry");
      cyc(1, 5, 14, 0); cyc(1, 4, 31, 0); cyc(1, 2, 23, 0); cyc(1, 1, 59, 0); cyc(1, 0, 59, 0);
      cyc(0, 0, 0, 1);
      chk_all("R6 month beyond 12");

      // R7: lock ignores field writes, control stays writable
      cyc(1, 8, 4, 0);
      rd_chk(8, "R7 lock bit set");
      cyc(1, 0, 33, 0); cyc(1, 4, 9, 0); cyc(1, 7, 8'h3C, 0);
      cyc(1, 8, 0, 0);
      chk_all("R7 writes ignored");

      // R8/R9: freeze snapshot
      cyc(1, 8, 2, 1);
      repeat (4) cyc(0, 0, 0, 1);
      chk_all("R8 held snapshot");
      cyc(1, 8, 0, 0);
      chk_all("R9 live after release");
      cyc(0, 0, 0, 1);
      rd_chk(0, "R9 follows counter");

      // R10: write and tick in the same cycle, carry still propagates
      cyc(1, 0, 59, 0);
      cyc(1, 0, 10, 1);
      rd_chk(0, "R10 write wins"); rd_chk(1, "R10 carry kept");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         bit w, t;
         int a, d, r;
         t = ($urandom % 2) == 1;
         w = ($urandom % 6) == 0;
         a = $urandom % 9;
         r = $urandom % 16;
         if (a == 8) d = ((r == 0) ? 4 : 0) | ($urandom % 4);
         else if (r == 0) d = 255;
         else if (a == 3) d = $urandom % 7;
         else if (a == 4) d = 1 + $urandom % 31;
         else if (a == 5) d = 1 + $urandom % 12;
         else if (a == 2) d = $urandom % 24;
         else d = $urandom % 100;
         cyc(w, a, d, t);
         if (!m_lock) rd_chk($urandom % 9, "R2 R3 R8 R9 random");
         else cyc(1, 8, 0, 0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule